// File: doc/BRIEF.md
# Shadow Stack Push and Check Unit

This unit runs the two shadow-stack operations of a processor core whose register width (XLEN) is 32 or 64. It holds the shadow stack pointer. A push moves the pointer down by one register width and stores the return address (the x1 value) at the new location. A pop-check reads the word at the current pointer and compares it with the alternate link register (the x5 value). When they match, the pointer moves up by one register width. When they differ, the unit raises a software-check fault and leaves the pointer where it was.

The pipeline gives the unit a single-cycle start strobe, the kind of operation, the enable that the permission logic has already worked out, and both register values. The unit then uses a request/acknowledge memory port. The access is one XLEN-wide word. The pointer changes only when the memory acknowledge arrives. When the enable is low, the operation still completes but does nothing: there is no memory access and the pointer does not move. Software can load the pointer directly through a register write port.

The unit also has a separate decoder for the compressed encodings that map onto these operations. These encodings sit in the quadrant-1 upper-immediate slot, with a zero immediate and an odd destination register.

Top module: `ssp_unit`

## Requirements
- R1: A push (op = 0) drives one write request whose address is the pointer minus XLEN/8 and whose data is `ra_val`. When it is acknowledged, the pointer takes that address.
- R2: A pop-check (op = 1) drives one read request at the current pointer. It compares `mem_rdata` with the `t0_val` captured at start.
- R3: On a pop-check whose read data equals `t0_val`, the pointer becomes the old pointer plus XLEN/8 and `fault` stays 0.
- R4: On a pop-check whose read data differs, the unit pulses `fault` together with `done`, with `fault_cause` = 18 and `fault_tval` = 3. The pointer keeps its value. When `fault` is 0, both `fault_cause` and `fault_tval` are 0.
- R5: While the unit waits for `mem_ack`, the pointer does not change. It changes on the clock edge that samples the acknowledge.
- R6: A start taken with `sse_en` = 0 makes no memory request and leaves the pointer unchanged. It pulses `done` in the next cycle.
- R7: After reset, the pointer is 0 and `busy`, `done` and `mem_req` are 0. `busy` and `mem_req` are 1 from the cycle after an enabled start until the cycle that samples `mem_ack`. `done` is 1 for the one cycle after that.
- R8: A `ptr_wr` while idle loads `ptr_wdata` into the pointer at the next edge. A start in the same cycle is dropped, with no `done` and no access. A `ptr_wr` while busy is ignored.
- R9: The decoder flags an encoding only when bits[1:0] = 01, bits[15:13] = 011, bit 12 = 0 and bits[6:2] = 0, with an odd rd in bits[11:7]. rd = 1 sets `c_push`, rd = 5 sets `c_popchk`, and any other odd rd sets `c_mop`. Every other encoding sets none of the three.
- R10: A start pulsed while busy is ignored. It produces no second access and no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation strobe |
| op | input | 1 | 0 = push, 1 = pop-check |
| sse_en | input | 1 | Effective shadow-stack enable |
| ra_val | input | XLEN | Return address to push (x1) |
| t0_val | input | XLEN | Reference for pop-check (x5) |
| ptr_wr | input | 1 | Direct pointer write |
| ptr_wdata | input | XLEN | Value for direct pointer write |
| c_insn | input | 16 | Compressed encoding to classify |
| c_push | output | 1 | Encoding is compressed push of x1 |
| c_popchk | output | 1 | Encoding is compressed pop-check of x5 |
| c_mop | output | 1 | Encoding is another odd-rd no-op |
| ssp | output | XLEN | Shadow stack pointer |
| busy | output | 1 | Memory access outstanding |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Pop-check mismatch, valid with done |
| fault_cause | output | 6 | Exception cause when fault |
| fault_tval | output | XLEN | Trap value when fault |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
Pushes run at acknowledge latencies of one, two and three cycles. This separates a pointer that commits on the acknowledge from one that commits at start. A chain of pushes is unwound by pop-checks whose reference matches, then broken by one whose reference differs, so that a correct increment is told apart from a missed fault and from a pointer that moves anyway. Disabled operations, a pointer write colliding with a start, and a pointer write plus a second start arriving while busy each check that the stray input leaves neither an access nor a `done` behind. The decoder is fed the two mapped encodings, other odd and even rd values, a non-zero immediate and a wrong quadrant.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    SS_PUSH   = 1'b0,
    SS_POPCHK = 1'b1
  } ss_op_e;

  localparam int unsigned CAUSE_W     = 6;
  localparam int unsigned SWCHK_CAUSE = 18;
  localparam int unsigned SS_TVAL     = 3;
endpackage

// File: rtl/ssp_cdecode.sv
module ssp_cdecode (
  input  logic [15:0] insn,
  output logic        is_push,
  output logic        is_popchk,
  output logic        is_mop
);
  logic       slot_hit;
  logic [4:0] rd;

  assign rd       = insn[11:7];
  assign slot_hit = (insn[1:0] == 2'b01) && (insn[15:13] == 3'b011) &&
                    !insn[12] && (insn[6:2] == 5'd0) && rd[0];

  assign is_push   = slot_hit && (rd == 5'd1);
  assign is_popchk = slot_hit && (rd == 5'd5);
  assign is_mop    = slot_hit && (rd != 5'd1) && (rd != 5'd5);
endmodule

// File: rtl/ssp_fsm.sv
module ssp_fsm
  import ssp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  ss_op_e op_in,
  input  logic   en,
  input  logic   ptr_wr,
  input  logic   mem_ack,
  input  logic   cmp_ok,
  output logic   busy,
  output logic   accept,
  output logic   commit,
  output ss_op_e op_q,
  output logic   done,
  output logic   fault
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e  st;
  logic idle, skip;

  assign idle   = (st == ST_IDLE);
  assign accept = idle && start && !ptr_wr && en;
  assign skip   = idle && start && !ptr_wr && !en;
  assign commit = (st == ST_WAIT) && mem_ack;
  assign busy   = (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      op_q  <= SS_PUSH;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      done  <= commit || skip;
      fault <= commit && (op_q == SS_POPCHK) && !cmp_ok;
      if (accept) begin
        st   <= ST_WAIT;
        op_q <= op_in;
      end else if (commit) begin
        st <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/ssp_ptr.sv
module ssp_ptr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] load_val,
  input  logic            step_dn,
  input  logic            step_up,
  output logic [XLEN-1:0] ptr,
  output logic [XLEN-1:0] ptr_dn,
  output logic [XLEN-1:0] ptr_up
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  function automatic logic [XLEN-1:0] below(input logic [XLEN-1:0] p);
    return p - STEP;
  endfunction

  function automatic logic [XLEN-1:0] above(input logic [XLEN-1:0] p);
    return p + STEP;
  endfunction

  assign ptr_dn = below(ptr);
  assign ptr_up = above(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= load_val;
    else if (step_dn) ptr <= ptr_dn;
    else if (step_up) ptr <= ptr_up;
  end
endmodule

// File: rtl/ssp_unit.sv
module ssp_unit
  import ssp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               op,
  input  logic               sse_en,
  input  logic [XLEN-1:0]    ra_val,
  input  logic [XLEN-1:0]    t0_val,
  input  logic               ptr_wr,
  input  logic [XLEN-1:0]    ptr_wdata,
  input  logic [15:0]        c_insn,
  output logic               c_push,
  output logic               c_popchk,
  output logic               c_mop,
  output logic [XLEN-1:0]    ssp,
  output logic               busy,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] fault_cause,
  output logic [XLEN-1:0]    fault_tval,
  output logic               mem_req,
  output logic               mem_we,
  output logic [XLEN-1:0]    mem_addr,
  output logic [XLEN-1:0]    mem_wdata,
  input  logic [XLEN-1:0]    mem_rdata,
  input  logic               mem_ack
);
  ss_op_e          op_q;
  logic            ev_accept, ev_commit, ev_match;
  logic            ev_ptr_load, ev_step_dn, ev_step_up;
  logic [XLEN-1:0] data_q, ptr_dn, ptr_up;

  ssp_cdecode cdec_i (
    .insn      (c_insn),
    .is_push   (c_push),
    .is_popchk (c_popchk),
    .is_mop    (c_mop)
  );

  ssp_fsm fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_in   (ss_op_e'(op)),
    .en      (sse_en),
    .ptr_wr  (ptr_wr),
    .mem_ack (mem_ack),
    .cmp_ok  (ev_match),
    .busy    (busy),
    .accept  (ev_accept),
    .commit  (ev_commit),
    .op_q    (op_q),
    .done    (done),
    .fault   (fault)
  );

  assign ev_match    = (mem_rdata == data_q);
  assign ev_ptr_load = ptr_wr && !busy;
  assign ev_step_dn  = ev_commit && (op_q == SS_PUSH);
  assign ev_step_up  = ev_commit && (op_q == SS_POPCHK) && ev_match;

  ssp_ptr #(.XLEN(XLEN)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_ptr_load),
    .load_val (ptr_wdata),
    .step_dn  (ev_step_dn),
    .step_up  (ev_step_up),
    .ptr      (ssp),
    .ptr_dn   (ptr_dn),
    .ptr_up   (ptr_up)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (ev_accept) data_q <= op ? t0_val : ra_val;
  end

  assign mem_req     = busy;
  assign mem_we      = busy && (op_q == SS_PUSH);
  assign mem_addr    = (op_q == SS_PUSH) ? ptr_dn : ssp;
  assign mem_wdata   = mem_we ? data_q : '0;
  assign fault_cause = fault ? CAUSE_W'(SWCHK_CAUSE) : '0;
  assign fault_tval  = fault ? XLEN'(SS_TVAL) : '0;
endmodule

// File: rtl/ssp_unit_chk.sv
module ssp_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            sse_en,
  input logic            ptr_wr,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] ssp,
  input logic            ev_commit
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  p_push_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == ssp - STEP));

  p_pop_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == ssp));

  p_fault_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && $stable(ssp)));

  p_hold_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> $stable(ssp));

  p_off_noacc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !sse_en && !ptr_wr) |=> (!busy && done));

  p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_ack_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (done && !busy));

  p_wr_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && !busy) |=> (!busy && !done));
endmodule

bind ssp_unit ssp_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .sse_en    (sse_en),
  .ptr_wr    (ptr_wr),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .ssp       (ssp),
  .ev_commit (ev_commit)
);

// File: tb/ssp_unit_tb_top.sv
`timescale 1ns/1ps
module ssp_unit_tb_top;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0, op = 1'b0, sse_en = 1'b1, ptr_wr = 1'b0;
  logic [XLEN-1:0] ra_val = '0, t0_val = '0, ptr_wdata = '0;
  logic [15:0]     c_insn = '0;
  logic            c_push, c_popchk, c_mop;
  logic [XLEN-1:0] ssp, fault_tval, mem_addr, mem_wdata;
  logic            busy, done, fault, mem_req, mem_we;
  logic [5:0]      fault_cause;
  logic [XLEN-1:0] mem_rdata = '0;
  logic            mem_ack = 1'b0;

  always #5 clk = ~clk;

  ssp_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sse_en(sse_en),
    .ra_val(ra_val), .t0_val(t0_val), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .c_insn(c_insn), .c_push(c_push), .c_popchk(c_popchk), .c_mop(c_mop),
    .ssp(ssp), .busy(busy), .done(done), .fault(fault),
    .fault_cause(fault_cause), .fault_tval(fault_tval),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  typedef struct {
    logic [XLEN-1:0] ptr;
    logic            flt;
    string           req;
  } exp_t;

  exp_t            sb[$];
  int              checks = 0, errors = 0;
  int              lat = 1, cnt = 0, acc_count = 0;
  logic [XLEN-1:0] mem [logic [XLEN-1:0]];
  logic [XLEN-1:0] last_wa = '0, last_wd = '0, last_ra = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges after lat request cycles
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      cnt++;
      if (cnt >= lat) begin
        mem_ack = 1'b1;
        acc_count++;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          last_wa = mem_addr;
          last_wd = mem_wdata;
        end else begin
          last_ra = mem_addr;
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : '0;
        end
      end
    end
  end

  // monitor: compares each completion with the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R10", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, "pointer", ssp, e.ptr);
        chk("R4", "fault", fault, e.flt);
        chk("R4", "cause", fault_cause, e.flt ? 64'd18 : 64'd0);
        chk("R4", "tval", fault_tval, e.flt ? 64'd3 : 64'd0);
      end
    end
  end

  task automatic wait_drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic o, input logic en, input logic [XLEN-1:0] ra,
                        input logic [XLEN-1:0] t0, input logic [XLEN-1:0] eptr,
                        input logic eflt, input string req);
    exp_t e;
    e.ptr = eptr; e.flt = eflt; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b1; op = o; sse_en = en; ra_val = ra; t0_val = t0;
    @(negedge clk);
    start = 1'b0; sse_en = 1'b1;
    wait_drain();
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual=hung expected=finished");
    checks++; errors++;
    summary();
    $finish;
  end

  initial begin
    int base;
    exp_t e;
    repeat (3) @(negedge clk);
    chk("R7", "reset ssp", ssp, 0);
    chk("R7", "reset busy", busy, 0);
    chk("R7", "reset done", done, 0);
    chk("R7", "reset mem_req", mem_req, 0);
    rst_n = 1'b1;

    // R8: direct load while idle
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = 32'h1000;
    @(negedge clk); ptr_wr = 1'b0;
    chk("R8", "direct load", ssp, 32'h1000);

    // R1: pushes at different latencies
    lat = 1;
    run_op(1'b0, 1'b1, 32'hCAFE0001, '0, 32'h0FFC, 1'b0, "R1");
    chk("R1", "push addr", last_wa, 32'h0FFC);
    chk("R1", "push data", last_wd, 32'hCAFE0001);
    lat = 3;
    run_op(1'b0, 1'b1, 32'h0BAD0002, '0, 32'h0FF8, 1'b0, "R1");

    // R7/R5: busy window with latency 2
    lat = 2;
    e.ptr = 32'h0FF4; e.flt = 1'b0; e.req = "R7";
    sb.push_back(e);
    @(negedge clk); start = 1'b1; op = 1'b0; ra_val = 32'h12345678;
    @(negedge clk); start = 1'b0;
    chk("R7", "busy after start", busy, 1);
    chk("R7", "mem_req after start", mem_req, 1);
    chk("R1", "write request", mem_we, 1);
    chk("R1", "request addr", mem_addr, 32'h0FF4);
    chk("R5", "ptr held while waiting", ssp, 32'h0FF8);
    @(negedge clk);
    chk("R7", "busy until ack", busy, 1);
    chk("R7", "no early done", done, 0);
    @(negedge clk);
    chk("R7", "done after ack", done, 1);
    chk("R7", "idle after ack", busy, 0);
    wait_drain();

    // R2/R3/R4: unwinding with pop-checks
    lat = 1;
    run_op(1'b1, 1'b1, '0, 32'h12345678, 32'h0FF8, 1'b0, "R3");
    chk("R2", "pop read addr", last_ra, 32'h0FF4);
    run_op(1'b1, 1'b1, '0, 32'h0000DEAD, 32'h0FF8, 1'b1, "R4");
    chk("R2", "mismatch read addr", last_ra, 32'h0FF8);
    lat = 2;
    run_op(1'b1, 1'b1, '0, 32'h0BAD0002, 32'h0FFC, 1'b0, "R3");

    // R6: disabled operations
    base = acc_count;
    run_op(1'b0, 1'b0, 32'h55555555, '0, 32'h0FFC, 1'b0, "R6");
    run_op(1'b1, 1'b0, '0, 32'h11111111, 32'h0FFC, 1'b0, "R6");
    chk("R6", "no access when disabled", acc_count, base);

    // R8: pointer write beats a start in the same cycle
    base = acc_count;
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = 32'h2000; start = 1'b1; op = 1'b0;
    @(negedge clk); ptr_wr = 1'b0; start = 1'b0;
    chk("R8", "write wins", ssp, 32'h2000);
    chk("R8", "start dropped", busy, 0);
    repeat (4) @(negedge clk);
    chk("R8", "no access from dropped start", acc_count, base);

    // R8/R10: pointer write and second start while busy
    lat = 5;
    base = acc_count;
    e.ptr = 32'h1FFC; e.flt = 1'b0; e.req = "R8";
    sb.push_back(e);
    @(negedge clk); start = 1'b1; op = 1'b0; ra_val = 32'hA5A5A5A5;
    @(negedge clk); start = 1'b0;
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = 32'h7777; start = 1'b1; op = 1'b1;
    @(negedge clk); ptr_wr = 1'b0; start = 1'b0;
    wait_drain();
    repeat (4) @(negedge clk);
    chk("R10", "single access", acc_count, base + 1);
    chk("R8", "busy write ignored", ssp, 32'h1FFC);

    // R9: compressed decode
    c_insn = 16'h6081; #1 chk("R9", "rd1", {c_push, c_popchk, c_mop}, 3'b100);
    c_insn = 16'h6281; #1 chk("R9", "rd5", {c_push, c_popchk, c_mop}, 3'b010);
    c_insn = 16'h6181; #1 chk("R9", "rd3", {c_push, c_popchk, c_mop}, 3'b001);
    c_insn = 16'h6381; #1 chk("R9", "rd7", {c_push, c_popchk, c_mop}, 3'b001);
    c_insn = 16'h6101; #1 chk("R9", "rd2", {c_push, c_popchk, c_mop}, 3'b000);
    c_insn = 16'h7081; #1 chk("R9", "imm", {c_push, c_popchk, c_mop}, 3'b000);
    c_insn = 16'h6082; #1 chk("R9", "quadrant", {c_push, c_popchk, c_mop}, 3'b000);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule